// File: doc/BRIEF.md
# SPI Register-Side Data Port

This block joins a 32-bit register bus to the byte-wide transmit and receive queues of a serial peripheral controller. A bus write to the data register loads bytes into the transmit queue, which the serial engine drains one byte at a time. The serial engine fills the receive queue one byte at a time, and a bus read of the data register takes bytes out. Both queues are held inside the block as parameterized storage. The serial shifter itself sits outside the block.

A packing flag in the format register selects the width of a data access. With the flag clear, one access moves one byte in bits 7:0. With the flag set, one access moves four bytes, and the lowest byte lane is always the earliest byte in the stream. The control register holds three self-clearing reset requests (serial core, receive queue, transmit queue) and two DMA enables. The status register reports the empty and full state of both queues. The configuration register reports each queue's depth as a log2 code. When its enable is set, each queue raises a DMA request while it can accept or deliver half its depth, which matches a burst of half the queue depth.

Bus accesses take a single cycle. `rdata_o` is a combinational function of `addr_i` and the current state. A data-register read removes its bytes at the clock edge where `req_i` is high.

Top module: `spi_data_port`

## Requirements
- R1: After reset, the control register reads 0, the format register reads 0, the status register reads 0x0040_4000 (both queues empty), the data register reads 0 and both DMA requests are low.
- R2: With the packing flag (format bit 7) clear, a data write enqueues only `wdata_i[7:0]`, and a data read returns one byte in bits 7:0 with bits 31:8 zero.
- R3: With the packing flag set, a data write enqueues four bytes, bits 7:0 first and bits 31:24 last. A data read dequeues four bytes, and the oldest byte appears in bits 7:0.
- R4: A write that finds too little room is dropped: a full queue in byte mode, or fewer than four free entries in packed mode. A read that finds too few bytes returns 0 and removes nothing: an empty queue in byte mode, or fewer than four stored bytes in packed mode.
- R5: Writing 1 to control bit 0, 1 or 2 makes that bit read 1 for exactly RST_CYCLES cycles after the write edge, after which it clears itself. Bit 2 empties the transmit queue. Bit 1 empties the receive queue. Bit 0 empties both queues and drives `core_rst_o` high for the same window.
- R6: Control bit 3 (receive DMA enable) and bit 4 (transmit DMA enable) are stored by a control write and read back.
- R7: `tx_dma_req_o` is high exactly when the transmit DMA enable is set and at least half the transmit queue is free. `rx_dma_req_o` is high exactly when the receive DMA enable is set and at least half the receive queue is filled.
- R8: Status bit 14 is receive-empty, bit 15 is receive-full, bit 22 is transmit-empty and bit 23 is transmit-full. All other status bits are 0.
- R9: The configuration register reads RX_AW-1 in bits 3:0 and TX_AW-1 in bits 7:4, so that a depth is 2^(code+1) entries. All other bits are 0.
- R10: The serial side dequeues transmit bytes in the order they were enqueued via `tx_pop_i`/`tx_byte_o`. A `rx_push_i` into a full receive queue is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word index: 0 data, 1 format, 2 control, 3 status, 4 configuration |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| core_rst_o | output | 1 | Reset to the serial engine during a core reset |
| tx_pop_i | input | 1 | Serial engine takes one transmit byte |
| tx_byte_o | output | 8 | Head of the transmit queue |
| tx_avail_o | output | 1 | Transmit queue holds at least one byte |
| rx_push_i | input | 1 | Serial engine delivers one received byte |
| rx_byte_i | input | 8 | Received byte |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |

## Verification
The hardest case to reach is a packed access that meets a partly filled queue. The status flags report full and empty per byte, so software polling those flags alone never creates the case of a write with one to three free entries, or a read with one to three stored bytes. The bench gets there by filling the queue in byte mode, switching the packing flag, and then issuing the packed access. It then drains in byte mode to show that nothing was added or removed. The self-clearing reset bits are sampled on every cycle of their window, so that a window that is one cycle long or one cycle short shows up.

// File: rtl/spi_dport_pkg.sv
package spi_dport_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_FMT  = 3'd1,
    REG_CTRL = 3'd2,
    REG_STAT = 3'd3,
    REG_CFG  = 3'd4
  } reg_sel_e;

  localparam int unsigned FMT_PACK    = 7;
  localparam int unsigned CTL_CORE    = 0;
  localparam int unsigned CTL_RXCLR   = 1;
  localparam int unsigned CTL_TXCLR   = 2;
  localparam int unsigned CTL_RXDMA   = 3;
  localparam int unsigned CTL_TXDMA   = 4;
  localparam int unsigned ST_RX_EMPTY = 14;
  localparam int unsigned ST_RX_FULL  = 15;
  localparam int unsigned ST_TX_EMPTY = 22;
  localparam int unsigned ST_TX_FULL  = 23;
endpackage

// File: rtl/spi_dport_fifo.sv
module spi_dport_fifo #(
  parameter int unsigned AW    = 4,
  parameter int unsigned LANES = 4,
  parameter int unsigned NW    = $clog2(LANES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic [NW-1:0]        push_n_i,
  input  logic [8*LANES-1:0]   push_data_i,
  input  logic [NW-1:0]        pop_n_i,
  output logic [8*LANES-1:0]   pop_data_o,
  output logic [AW:0]          count_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;

  always_ff @(posedge clk_i) begin
    if (!clr_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (NW'(k) < push_n_i) mem[wr_ptr + AW'(k)] <= push_data_i[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n_i);
      rd_ptr <= rd_ptr + AW'(pop_n_i);
      cnt    <= cnt + (AW+1)'(push_n_i) - (AW+1)'(pop_n_i);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign pop_data_o[8*k +: 8] = mem[rd_ptr + AW'(k)];
  end

  assign count_o = cnt;

  // R4: callers never ask for more than the storage holds
  a_r4_push_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> ((AW+1)'(push_n_i) <= (AW+1)'(DEPTH) - cnt));
  a_r4_pop_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> ((AW+1)'(pop_n_i) <= cnt));
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= (AW+1)'(DEPTH));
  a_r5_clr_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0));
endmodule

// File: rtl/spi_dport_rst_seq.sv
module spi_dport_rst_seq #(
  parameter int unsigned CYCLES = 4,
  parameter int unsigned CW     = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start_i) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign busy_o = busy;

  a_r5_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(CYCLES - 1));
  a_r5_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt == '0 && !start_i) |=> !busy_o);
endmodule

// File: rtl/spi_data_port.sv
module spi_data_port #(
  parameter int unsigned TX_AW      = 4,
  parameter int unsigned RX_AW      = 4,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        core_rst_o,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_byte_o,
  output logic        tx_avail_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_byte_i,
  output logic        tx_dma_req_o,
  output logic        rx_dma_req_o
);
  import spi_dport_pkg::*;

  localparam int unsigned TX_DEPTH = 1 << TX_AW;
  localparam int unsigned RX_DEPTH = 1 << RX_AW;
  localparam int unsigned NW       = $clog2(LANES + 1);
  localparam int unsigned NSEQ     = 3;

  logic pack_q, rx_dma_en_q, tx_dma_en_q;

  logic wr_data, rd_data, wr_fmt, wr_ctrl;
  assign wr_data = req_i &&  we_i && addr_i == REG_DATA;
  assign rd_data = req_i && !we_i && addr_i == REG_DATA;
  assign wr_fmt  = req_i &&  we_i && addr_i == REG_FMT;
  assign wr_ctrl = req_i &&  we_i && addr_i == REG_CTRL;

  // self-clearing reset requests: core, rx clear, tx clear
  logic [NSEQ-1:0] seq_start, seq_busy;
  for (genvar g = 0; g < NSEQ; g++) begin : g_seq
    assign seq_start[g] = wr_ctrl && wdata_i[g];
    spi_dport_rst_seq #(.CYCLES(RST_CYCLES)) i_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (seq_start[g]),
      .busy_o  (seq_busy[g])
    );
  end

  logic tx_clr, rx_clr;
  assign tx_clr     = seq_busy[CTL_CORE] | seq_busy[CTL_TXCLR];
  assign rx_clr     = seq_busy[CTL_CORE] | seq_busy[CTL_RXCLR];
  assign core_rst_o = seq_busy[CTL_CORE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pack_q      <= 1'b0;
      rx_dma_en_q <= 1'b0;
      tx_dma_en_q <= 1'b0;
    end else begin
      if (wr_fmt) pack_q <= wdata_i[FMT_PACK];
      if (wr_ctrl) begin
        rx_dma_en_q <= wdata_i[CTL_RXDMA];
        tx_dma_en_q <= wdata_i[CTL_TXDMA];
      end
    end
  end

  logic [NW-1:0] need_n;
  assign need_n = pack_q ? NW'(LANES) : NW'(1);

  // transmit queue
  logic [TX_AW:0]  tx_cnt, tx_free;
  logic [NW-1:0]   tx_push_n, tx_pop_n;
  logic [31:0]     tx_push_data, tx_pop_data;
  logic            tx_room;

  assign tx_free      = (TX_AW+1)'(TX_DEPTH) - tx_cnt;
  assign tx_room      = !tx_clr && tx_free >= (TX_AW+1)'(need_n);
  assign tx_push_n    = (wr_data && tx_room) ? need_n : '0;
  assign tx_push_data = pack_q ? wdata_i : {24'd0, wdata_i[7:0]};
  assign tx_avail_o   = !tx_clr && tx_cnt != '0;
  assign tx_pop_n     = (tx_pop_i && tx_avail_o) ? NW'(1) : '0;

  spi_dport_fifo #(.AW(TX_AW), .LANES(LANES)) i_tx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (tx_clr),
    .push_n_i    (tx_push_n),
    .push_data_i (tx_push_data),
    .pop_n_i     (tx_pop_n),
    .pop_data_o  (tx_pop_data),
    .count_o     (tx_cnt)
  );

  assign tx_byte_o = tx_pop_data[7:0];
  logic unused_tx_lanes;
  assign unused_tx_lanes = ^tx_pop_data[31:8];

  // receive queue
  logic [RX_AW:0]  rx_cnt;
  logic [NW-1:0]   rx_push_n, rx_pop_n;
  logic [31:0]     rx_pop_data;
  logic            rx_ok;

  assign rx_push_n = (rx_push_i && !rx_clr && rx_cnt != (RX_AW+1)'(RX_DEPTH)) ? NW'(1) : '0;
  assign rx_ok     = !rx_clr && rx_cnt >= (RX_AW+1)'(need_n);
  assign rx_pop_n  = (rd_data && rx_ok) ? need_n : '0;

  spi_dport_fifo #(.AW(RX_AW), .LANES(LANES)) i_rx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (rx_clr),
    .push_n_i    (rx_push_n),
    .push_data_i ({24'd0, rx_byte_i}),
    .pop_n_i     (rx_pop_n),
    .pop_data_o  (rx_pop_data),
    .count_o     (rx_cnt)
  );

  // DMA requests at the half-depth watermark
  assign tx_dma_req_o = tx_dma_en_q && tx_free >= (TX_AW+1)'(TX_DEPTH / 2);
  assign rx_dma_req_o = rx_dma_en_q && rx_cnt  >= (RX_AW+1)'(RX_DEPTH / 2);

  // read mux
  logic [31:0] stat_w, ctrl_w, data_w;
  always_comb begin
    stat_w              = '0;
    stat_w[ST_RX_EMPTY] = rx_cnt == '0;
    stat_w[ST_RX_FULL]  = rx_cnt == (RX_AW+1)'(RX_DEPTH);
    stat_w[ST_TX_EMPTY] = tx_cnt == '0;
    stat_w[ST_TX_FULL]  = tx_cnt == (TX_AW+1)'(TX_DEPTH);
    ctrl_w              = '0;
    ctrl_w[NSEQ-1:0]    = seq_busy;
    ctrl_w[CTL_RXDMA]   = rx_dma_en_q;
    ctrl_w[CTL_TXDMA]   = tx_dma_en_q;
    if (!rx_ok)      data_w = '0;
    else if (pack_q) data_w = rx_pop_data;
    else             data_w = {24'd0, rx_pop_data[7:0]};
  end

  always_comb begin
    unique case (addr_i)
      REG_DATA: rdata_o = data_w;
      REG_FMT:  rdata_o = {24'd0, pack_q, 7'd0};
      REG_CTRL: rdata_o = ctrl_w;
      REG_STAT: rdata_o = stat_w;
      REG_CFG:  rdata_o = {24'd0, 4'(TX_AW - 1), 4'(RX_AW - 1)};
      default:  rdata_o = '0;
    endcase
  end

  // R4: a byte write into a full transmit queue leaves its fill level alone
  a_r4_drop_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !tx_clr && !tx_pop_i && tx_cnt == (TX_AW+1)'(TX_DEPTH)) |=> $stable(tx_cnt));
  // R4: an empty read removes nothing
  a_r4_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !rx_clr && !rx_push_i && rx_cnt == '0) |=> (rx_cnt == '0));
  // R7: no request while the matching enable is off
  a_r7_dma_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!tx_dma_en_q -> !tx_dma_req_o) && (!rx_dma_en_q -> !rx_dma_req_o)));
endmodule

// File: tb/test_spi_data_port.sv
module test_spi_data_port;
  localparam int AW = 3;
  localparam int DEPTH = 8;
  localparam int RC = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        core_rst, tx_pop = 1'b0, tx_avail, rx_push = 1'b0;
  logic [7:0]  tx_byte, rx_byte = '0;
  logic        tx_req, rx_req;

  spi_data_port #(.TX_AW(AW), .RX_AW(AW), .RST_CYCLES(RC)) i_spi_data_port (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .core_rst_o(core_rst),
    .tx_pop_i(tx_pop), .tx_byte_o(tx_byte), .tx_avail_o(tx_avail),
    .rx_push_i(rx_push), .rx_byte_i(rx_byte),
    .tx_dma_req_o(tx_req), .rx_dma_req_o(rx_req));

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 0;
  logic [7:0] tx_q[$];
  logic [31:0] rd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] st(bit rxe, bit rxf, bit txe, bit txf);
    return (32'(rxe) << 14) | (32'(rxf) << 15) | (32'(txe) << 22) | (32'(txf) << 23);
  endfunction

  // monitor: every transmit byte taken by the serial side is scored
  always @(negedge clk) begin
    #2;
    if (tx_pop && tx_avail) begin
      if (tx_q.size() == 0) chk("R10 unexpected tx byte", {24'd0, tx_byte}, 32'hxx);
      else chk("R10 tx order", {24'd0, tx_byte}, {24'd0, tx_q.pop_front()});
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a; #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic wr_exp(input logic [31:0] d, input bit pack);
    bus_wr(3'd0, d);
    if (pack) for (int k = 0; k < 4; k++) tx_q.push_back(d[8*k +: 8]);
    else tx_q.push_back(d[7:0]);
  endtask

  task automatic core_push(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_byte = b;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic drain;
    #2;
    while (tx_avail) begin
      @(negedge clk); tx_pop = 1;
      @(negedge clk); tx_pop = 0;
      #2;
    end
    chk("R10 scoreboard empty", 32'(tx_q.size()), 32'd0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_rd(3'd2, rd); chk("R1 ctrl", rd, 0);
    bus_rd(3'd1, rd); chk("R1 fmt", rd, 0);
    bus_rd(3'd3, rd); chk("R1 status", rd, 32'h0040_4000);
    bus_rd(3'd0, rd); chk("R1 data", rd, 0);
    chk("R1 dma reqs", {30'd0, tx_req, rx_req}, 0);
    bus_rd(3'd4, rd); chk("R9 cfg", rd, 32'h22);

    // R2 byte-mode write
    wr_exp(32'hAABB_CC11, 0);
    wr_exp(32'h0000_0022, 0);
    drain();

    // R3 packed write
    bus_wr(3'd1, 32'h80);
    bus_rd(3'd1, rd); chk("R3 fmt readback", rd, 32'h80);
    wr_exp(32'h4433_2211, 1);
    wr_exp(32'hDEAD_BEEF, 1);
    drain();

    // R4/R8 full transmit queue in byte mode
    bus_wr(3'd1, 0);
    for (int i = 0; i < DEPTH; i++) wr_exp(32'(i + 8'h30), 0);
    bus_rd(3'd3, rd); chk("R8 tx full", rd, st(1, 0, 0, 1));
    bus_wr(3'd0, 32'hEE);
    drain();
    bus_rd(3'd3, rd); chk("R8 tx empty after drain", rd, st(1, 0, 1, 0));

    // R4 packed write with only two free entries is dropped
    for (int i = 0; i < 6; i++) wr_exp(32'(i + 8'h60), 0);
    bus_wr(3'd1, 32'h80);
    bus_wr(3'd0, 32'h9988_7766);
    bus_wr(3'd1, 0);
    drain();

    // R2 byte-mode read, R4 empty read
    core_push(8'h5A); core_push(8'hA5);
    bus_rd(3'd0, rd); chk("R2 rx byte0", rd, 32'h5A);
    bus_rd(3'd0, rd); chk("R2 rx byte1", rd, 32'hA5);
    bus_rd(3'd0, rd); chk("R4 empty read zero", rd, 0);
    bus_rd(3'd3, rd); chk("R4 still empty", rd, st(1, 0, 1, 0));

    // R3 packed read, R4 short packed read
    bus_wr(3'd1, 32'h80);
    for (int i = 1; i <= 4; i++) core_push(8'(i));
    bus_rd(3'd0, rd); chk("R3 packed read", rd, 32'h0403_0201);
    core_push(8'hC1); core_push(8'hC2); core_push(8'hC3);
    bus_rd(3'd0, rd); chk("R4 short packed read zero", rd, 0);
    bus_wr(3'd1, 0);
    bus_rd(3'd0, rd); chk("R4 nothing removed b0", rd, 32'hC1);
    bus_rd(3'd0, rd); chk("R4 nothing removed b1", rd, 32'hC2);
    bus_rd(3'd0, rd); chk("R4 nothing removed b2", rd, 32'hC3);

    // R10/R8 receive overflow
    for (int i = 0; i <= DEPTH; i++) core_push(8'(8'h70 + i));
    bus_rd(3'd3, rd); chk("R8 rx full", rd, st(0, 1, 1, 0));
    for (int i = 0; i < DEPTH; i++) begin
      bus_rd(3'd0, rd); chk("R10 rx order", rd, 32'(8'h70 + i));
    end
    bus_rd(3'd3, rd); chk("R10 extra byte dropped", rd, st(1, 0, 1, 0));

    // R6/R7 DMA enables and watermarks
    bus_wr(3'd2, 32'h18);
    bus_rd(3'd2, rd); chk("R6 dma enables", rd, 32'h18);
    #1 chk("R7 tx req empty", {31'd0, tx_req}, 1);
    for (int i = 0; i < 4; i++) wr_exp(32'(8'hA0 + i), 0);
    #1 chk("R7 tx req half free", {31'd0, tx_req}, 1);
    wr_exp(32'hA4, 0);
    #1 chk("R7 tx req below half", {31'd0, tx_req}, 0);
    drain();
    for (int i = 0; i < 3; i++) core_push(8'(i));
    #1 chk("R7 rx req below half", {31'd0, rx_req}, 0);
    core_push(8'h03);
    #1 chk("R7 rx req half full", {31'd0, rx_req}, 1);
    for (int i = 0; i < 4; i++) bus_rd(3'd0, rd);
    bus_wr(3'd2, 0);
    #1 chk("R7 disabled", {30'd0, tx_req, rx_req}, 0);

    // R5 transmit clear window
    bus_wr(3'd0, 32'h11); bus_wr(3'd0, 32'h12);
    bus_wr(3'd2, 32'h04);
    addr = 3'd2;
    for (int c = 1; c <= RC + 1; c++) begin
      #1 chk("R5 tx clear window", rdata, (c <= RC) ? 32'h04 : 32'h00);
      @(negedge clk);
    end
    bus_rd(3'd3, rd); chk("R5 tx cleared", rd, st(1, 0, 1, 0));

    // R5 receive clear leaves transmit alone
    wr_exp(32'h55, 0);
    core_push(8'h01);
    bus_wr(3'd2, 32'h02);
    repeat (RC + 1) @(negedge clk);
    bus_rd(3'd3, rd); chk("R5 rx cleared only", rd, st(1, 0, 0, 0));
    drain();

    // R5 core reset empties both and drives core_rst_o
    bus_wr(3'd0, 32'h21);
    core_push(8'h02);
    bus_wr(3'd2, 32'h01);
    for (int c = 1; c <= RC + 1; c++) begin
      #1 chk("R5 core reset out", {31'd0, core_rst}, (c <= RC) ? 1 : 0);
      @(negedge clk);
    end
    bus_rd(3'd3, rd); chk("R5 core reset empties", rd, st(1, 0, 1, 0));
    bus_rd(3'd2, rd); chk("R5 ctrl self-cleared", rd, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule